// File: doc/BRIEF.md
# Shared I/O Pin Ownership Controller

This block controls one port of general-purpose pins, each of which several on-chip sources can drive. For every pin it holds a latch bit, a direction bit and an open-drain bit, and it decides each cycle which source drives the pad. The order is fixed:

1. A debug-port override.
2. A trace-port override.
3. A ranked list of peripheral drive slots.
4. The port's own latch.

A peripheral takes a pin only while it raises its drive request for that pin. An enabled peripheral that is idle leaves the pin to the port.

The pad level goes through a two-flop synchronizer. The synchronized level is the value software reads back and the value peripheral inputs see. Two input paths are brought out:

- **Stimulus-capable path** (interrupt, timer clock, capture and fault inputs). While the port drives a pin as an output, this path returns the latch bit, so software can exercise those inputs with nothing connected to the pad.
- **Isolated path** (serial interfaces). This path always carries the pad level and is never fed from the latch.

A small register bus gives access to the latch, direction, open-drain and override controls, and to the synchronized pad level.

Top module: `pin_owner_ctrl`

## Requirements
- R1: After reset, the latch, direction and open-drain registers read 0, the control register reads 1 (debug override on, trace override off), and no port or peripheral drives any pad.
- R2: A pin that the port owns, with direction 1 (output) and open-drain bit 1, drives only low: pad_oe is the inverse of the latch bit and pad_out is 0.
- R3: A pin that the port owns, with direction 1 and open-drain bit 0, drives push-pull: pad_oe=1 and pad_out equals the latch bit. With direction 0 the pin is not driven (pad_oe=0, pad_out=0).
- R4: While any peripheral slot requests a non-overridden pin, that peripheral drives it (pad_oe=1, pad_out equals the slot data), whatever the latch, direction and open-drain bits are. The port can still read the pin level.
- R5: Slot 0 ranks highest and slot NUM_SLOTS-1 lowest. Among the slots requesting a pin, the lowest-numbered one wins. Slots that do not request a pin have no effect on it.
- R6: While control bit 0 (debug override) is 1, every pin in DBG_MASK takes pad_oe from dbg_oe_i and pad_out from dbg_out_i. Clearing the bit returns those pins to peripheral or port control.
- R7: While control bit 1 (trace override) is 1, every pin in TRC_MASK has pad_oe=1 and pad_out equal to trc_out_i.
- R8: The debug override wins over trace, peripherals and port. The trace override wins over peripherals and port.
- R9: soft_in_o returns the latch bit for any pin that the port owns with direction 1. For every other pin it returns the synchronized pad level.
- R10: ser_in_o and the port-read register both return pad_in_i through a two-flop synchronizer, so a change shows after two rising clock edges. The port owner and the latch have no effect on them.
- R11: The register addresses are: 0 latch, 1 direction, 2 open-drain, 3 synchronized pad level (read only), 4 control (bit 0 debug, bit 1 trace). A write takes effect at the next rising edge. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | NUM_PINS | Write data |
| rd_data_o | output | NUM_PINS | Read data for addr_i |
| per_req_i | input | NUM_SLOTS*NUM_PINS | Peripheral drive requests, bit slot*NUM_PINS+pin |
| per_dat_i | input | NUM_SLOTS*NUM_PINS | Peripheral output data, same indexing |
| dbg_oe_i | input | NUM_PINS | Debug interface output enables |
| dbg_out_i | input | NUM_PINS | Debug interface output data |
| trc_out_i | input | NUM_PINS | Trace output data |
| pad_in_i | input | NUM_PINS | Pad input level |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| pad_out_o | output | NUM_PINS | Pad output data |
| soft_in_o | output | NUM_PINS | Stimulus-capable peripheral input |
| ser_in_o | output | NUM_PINS | Isolated peripheral input |

## Verification
The assertions check four properties on every cycle:
- a slot-0 request always controls a non-overridden pad;
- an open-drain pin owned by the port never drives high;
- debug-owned pins follow the debug enables;
- both read paths return the input as it stood two edges earlier.

The directed scenarios are needed for the behaviour that depends on sequence and intent:
- the reset values;
- rank between lower slots;
- handing pins back when an override bit clears;
- trace taking priority over peripherals;
- the latch feeding only the stimulus-capable input path.

// File: rtl/pin_owner_pkg.sv
package pin_owner_pkg;
  typedef enum logic [2:0] {
    A_LAT  = 3'd0,
    A_DIR  = 3'd1,
    A_ODC  = 3'd2,
    A_PAD  = 3'd3,
    A_CTRL = 3'd4
  } reg_addr_e;

  typedef enum logic [1:0] {
    OWN_PORT = 2'd0,
    OWN_PER  = 2'd1,
    OWN_TRC  = 2'd2,
    OWN_DBG  = 2'd3
  } owner_e;
endpackage

// File: rtl/pin_owner_sync.sv
module pin_owner_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pin_owner_regs.sv
module pin_owner_regs
  import pin_owner_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [2:0]          addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] pad_sync_i,
  output logic [NUM_PINS-1:0] lat_o,
  output logic [NUM_PINS-1:0] dir_o,
  output logic [NUM_PINS-1:0] odc_o,
  output logic                dbg_en_o,
  output logic                trc_en_o,
  output logic [NUM_PINS-1:0] rd_data_o
);
  logic [NUM_PINS-1:0] lat_q, dir_q, odc_q;
  logic                dbg_en_q, trc_en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q    <= '0;
      dir_q    <= '0;
      odc_q    <= '0;
      dbg_en_q <= 1'b1;
      trc_en_q <= 1'b0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_LAT:  lat_q <= wdata_i;
        A_DIR:  dir_q <= wdata_i;
        A_ODC:  odc_q <= wdata_i;
        A_CTRL: begin
          dbg_en_q <= wdata_i[0];
          trc_en_q <= wdata_i[1];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data_o = '0;
    unique case (addr_i)
      A_LAT:  rd_data_o = lat_q;
      A_DIR:  rd_data_o = dir_q;
      A_ODC:  rd_data_o = odc_q;
      A_PAD:  rd_data_o = pad_sync_i;
      A_CTRL: begin
        rd_data_o[0] = dbg_en_q;
        rd_data_o[1] = trc_en_q;
      end
      default: rd_data_o = '0;
    endcase
  end

  assign lat_o    = lat_q;
  assign dir_o    = dir_q;
  assign odc_o    = odc_q;
  assign dbg_en_o = dbg_en_q;
  assign trc_en_o = trc_en_q;
endmodule

// File: rtl/pin_owner_arb.sv
module pin_owner_arb
  import pin_owner_pkg::*;
#(
  parameter int NUM_SLOTS = 3
) (
  input  logic [NUM_SLOTS-1:0] req_i,
  input  logic [NUM_SLOTS-1:0] dat_i,
  input  logic                 lat_i,
  input  logic                 dir_i,
  input  logic                 odc_i,
  input  logic                 dbg_sel_i,
  input  logic                 dbg_oe_i,
  input  logic                 dbg_out_i,
  input  logic                 trc_sel_i,
  input  logic                 trc_out_i,
  input  logic                 pad_sync_i,
  output logic                 oe_o,
  output logic                 out_o,
  output logic                 soft_in_o
);
  owner_e owner;
  logic   per_hit, per_dat;

  // Scan low rank to high so slot 0 lands last and wins
  always_comb begin
    per_hit = 1'b0;
    per_dat = 1'b0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (req_i[s]) begin
        per_hit = 1'b1;
        per_dat = dat_i[s];
      end
    end
  end

  always_comb begin
    if (dbg_sel_i)      owner = OWN_DBG;
    else if (trc_sel_i) owner = OWN_TRC;
    else if (per_hit)   owner = OWN_PER;
    else                owner = OWN_PORT;
  end

  always_comb begin
    unique case (owner)
      OWN_DBG: begin oe_o = dbg_oe_i; out_o = dbg_out_i; end
      OWN_TRC: begin oe_o = 1'b1;     out_o = trc_out_i; end
      OWN_PER: begin oe_o = 1'b1;     out_o = per_dat;   end
      default: begin
        if (!dir_i)     begin oe_o = 1'b0;   out_o = 1'b0;  end
        else if (odc_i) begin oe_o = ~lat_i; out_o = 1'b0;  end
        else            begin oe_o = 1'b1;   out_o = lat_i; end
      end
    endcase
  end

  assign soft_in_o = (owner == OWN_PORT && dir_i) ? lat_i : pad_sync_i;
endmodule

// File: rtl/pin_owner_ctrl.sv
module pin_owner_ctrl
  import pin_owner_pkg::*;
#(
  parameter int                  NUM_PINS  = 8,
  parameter int                  NUM_SLOTS = 3,
  parameter logic [NUM_PINS-1:0] DBG_MASK  = 8'h03,
  parameter logic [NUM_PINS-1:0] TRC_MASK  = 8'h30
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [2:0]                    addr_i,
  input  logic [NUM_PINS-1:0]           wdata_i,
  output logic [NUM_PINS-1:0]           rd_data_o,
  input  logic [NUM_SLOTS*NUM_PINS-1:0] per_req_i,
  input  logic [NUM_SLOTS*NUM_PINS-1:0] per_dat_i,
  input  logic [NUM_PINS-1:0]           dbg_oe_i,
  input  logic [NUM_PINS-1:0]           dbg_out_i,
  input  logic [NUM_PINS-1:0]           trc_out_i,
  input  logic [NUM_PINS-1:0]           pad_in_i,
  output logic [NUM_PINS-1:0]           pad_oe_o,
  output logic [NUM_PINS-1:0]           pad_out_o,
  output logic [NUM_PINS-1:0]           soft_in_o,
  output logic [NUM_PINS-1:0]           ser_in_o
);
  logic [NUM_PINS-1:0] pad_sync, lat_q, dir_q, odc_q;
  logic                dbg_en_q, trc_en_q;

  pin_owner_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pad_sync)
  );

  pin_owner_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .pad_sync_i (pad_sync),
    .lat_o      (lat_q),
    .dir_o      (dir_q),
    .odc_o      (odc_q),
    .dbg_en_o   (dbg_en_q),
    .trc_en_o   (trc_en_q),
    .rd_data_o  (rd_data_o)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_SLOTS-1:0] req, dat;
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      assign req[s] = per_req_i[s*NUM_PINS + p];
      assign dat[s] = per_dat_i[s*NUM_PINS + p];
    end

    pin_owner_arb #(.NUM_SLOTS(NUM_SLOTS)) u_arb (
      .req_i      (req),
      .dat_i      (dat),
      .lat_i      (lat_q[p]),
      .dir_i      (dir_q[p]),
      .odc_i      (odc_q[p]),
      .dbg_sel_i  (dbg_en_q & DBG_MASK[p]),
      .dbg_oe_i   (dbg_oe_i[p]),
      .dbg_out_i  (dbg_out_i[p]),
      .trc_sel_i  (trc_en_q & TRC_MASK[p]),
      .trc_out_i  (trc_out_i[p]),
      .pad_sync_i (pad_sync[p]),
      .oe_o       (pad_oe_o[p]),
      .out_o      (pad_out_o[p]),
      .soft_in_o  (soft_in_o[p])
    );
  end

  assign ser_in_o = pad_sync;
endmodule

// File: rtl/pin_owner_ctrl_chk.sv
module pin_owner_ctrl_chk
  import pin_owner_pkg::*;
#(
  parameter int                  NUM_PINS  = 8,
  parameter int                  NUM_SLOTS = 3,
  parameter logic [NUM_PINS-1:0] DBG_MASK  = 8'h03,
  parameter logic [NUM_PINS-1:0] TRC_MASK  = 8'h30
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [2:0]                    addr_i,
  input logic [NUM_PINS-1:0]           rd_data_o,
  input logic [NUM_SLOTS*NUM_PINS-1:0] per_req_i,
  input logic [NUM_SLOTS*NUM_PINS-1:0] per_dat_i,
  input logic [NUM_PINS-1:0]           dbg_oe_i,
  input logic [NUM_PINS-1:0]           pad_in_i,
  input logic [NUM_PINS-1:0]           pad_oe_o,
  input logic [NUM_PINS-1:0]           pad_out_o,
  input logic [NUM_PINS-1:0]           ser_in_o,
  input logic [NUM_PINS-1:0]           odc_q,
  input logic                          dbg_en_q,
  input logic                          trc_en_q
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R10: both read paths show the input from two edges back
  p_sync_delay_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2) |-> (ser_in_o == $past(pad_in_i, 2)));

  p_port_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_PAD) |-> (rd_data_o == ser_in_o));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    logic any_req;
    logic ovr;
    always_comb begin
      any_req = 1'b0;
      for (int s = 0; s < NUM_SLOTS; s++) any_req |= per_req_i[s*NUM_PINS + p];
    end
    assign ovr = (dbg_en_q & DBG_MASK[p]) | (trc_en_q & TRC_MASK[p]);

    p_slot0_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ovr && per_req_i[p]) |-> (pad_oe_o[p] && pad_out_o[p] == per_dat_i[p]));

    p_od_no_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ovr && !any_req && odc_q[p]) |-> !pad_out_o[p]);

    if (DBG_MASK[p]) begin : g_dbg
      p_dbg_owns_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dbg_en_q |-> (pad_oe_o[p] == dbg_oe_i[p]));
    end
  end
endmodule

bind pin_owner_ctrl pin_owner_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .NUM_SLOTS(NUM_SLOTS),
  .DBG_MASK (DBG_MASK),
  .TRC_MASK (TRC_MASK)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .per_req_i (per_req_i),
  .per_dat_i (per_dat_i),
  .dbg_oe_i  (dbg_oe_i),
  .pad_in_i  (pad_in_i),
  .pad_oe_o  (pad_oe_o),
  .pad_out_o (pad_out_o),
  .ser_in_o  (ser_in_o),
  .odc_q     (odc_q),
  .dbg_en_q  (dbg_en_q),
  .trc_en_q  (trc_en_q)
);

// File: tb/pin_owner_ctrl_tb_top.sv
module pin_owner_ctrl_tb_top;
  localparam int NP = 8;
  localparam int NS = 3;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [NP-1:0] wdata_i = '0;
  logic [NP-1:0] rd_data_o;
  logic [NS*NP-1:0] per_req_i = '0;
  logic [NS*NP-1:0] per_dat_i = '0;
  logic [NP-1:0] dbg_oe_i = '0, dbg_out_i = '0, trc_out_i = '0, pad_in_i = '0;
  logic [NP-1:0] pad_oe_o, pad_out_o, soft_in_o, ser_in_o;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk_i = ~clk_i;

  pin_owner_ctrl dut_i (.*);

  task automatic check(input string tag, input logic [NP-1:0] got, input logic [NP-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [NP-1:0] d);
    addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  task automatic settle2();
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    logic [NP-1:0] v;
    rd(3'd0, v); check("R1 lat", v, 8'h00);
    rd(3'd1, v); check("R1 dir", v, 8'h00);
    rd(3'd2, v); check("R1 odc", v, 8'h00);
    rd(3'd4, v); check("R1 R11 ctrl", v, 8'h01);
    check("R1 oe", pad_oe_o, 8'h00);
  endtask

  task automatic t_push_pull();
    wr(3'd4, 8'h00);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hA5);
    check("R3 oe", pad_oe_o, 8'hFF);
    check("R3 out", pad_out_o, 8'hA5);
    wr(3'd1, 8'h0F);
    check("R3 oe dir", pad_oe_o, 8'h0F);
    check("R3 out dir", pad_out_o, 8'h05);
  endtask

  task automatic t_open_drain();
    wr(3'd1, 8'hFF);
    wr(3'd2, 8'hFF);
    check("R2 oe", pad_oe_o, 8'h5A);
    check("R2 out", pad_out_o, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_periph();
    logic [NP-1:0] v;
    wr(3'd0, 8'h00);
    @(negedge clk_i);
    per_req_i[2*NP+2] = 1'b1; per_dat_i[2*NP+2] = 1'b1;
    #1 check("R4 slot2 out", pad_out_o, 8'h04);
    check("R4 oe", pad_oe_o, 8'hFF);
    per_req_i[1*NP+2] = 1'b1; per_dat_i[1*NP+2] = 1'b0;
    #1 check("R5 slot1 over slot2", pad_out_o, 8'h00);
    per_req_i[2] = 1'b1; per_dat_i[2] = 1'b1;
    #1 check("R5 slot0 over slot1", pad_out_o, 8'h04);
    pad_in_i = 8'h3C;
    settle2();
    rd(3'd3, v); check("R4 R10 read under periph", v, 8'h3C);
    per_req_i = '0;
    #1 check("R5 idle slots no effect", pad_out_o, 8'h00);
    wr(3'd1, 8'h00);
    check("R4 dir input", pad_oe_o, 8'h00);
  endtask

  task automatic t_debug();
    @(negedge clk_i);
    dbg_oe_i = 8'h03; dbg_out_i = 8'h01;
    per_req_i[0] = 1'b1; per_dat_i[0] = 1'b0;
    wr(3'd4, 8'h01);
    check("R6 R8 dbg oe", pad_oe_o, 8'h03);
    check("R6 R8 dbg out", pad_out_o, 8'h01);
    wr(3'd4, 8'h00);
    check("R6 release oe", pad_oe_o, 8'h01);
    check("R6 release out", pad_out_o, 8'h00);
    per_req_i = '0; per_dat_i = '0; dbg_oe_i = '0; dbg_out_i = '0;
  endtask

  task automatic t_trace();
    @(negedge clk_i);
    trc_out_i = 8'h20;
    per_req_i[4] = 1'b1; per_dat_i[4] = 1'b1;
    wr(3'd4, 8'h02);
    check("R7 R8 trc oe", pad_oe_o, 8'h30);
    check("R7 R8 trc out", pad_out_o, 8'h20);
    wr(3'd4, 8'h00);
    check("R7 off", pad_out_o, 8'h10);
    per_req_i = '0; per_dat_i = '0; trc_out_i = '0;
  endtask

  task automatic t_loop();
    @(negedge clk_i);
    pad_in_i = 8'hC0;
    wr(3'd1, 8'h0F);
    wr(3'd0, 8'h05);
    settle2();
    check("R9 soft loop", soft_in_o, 8'hC5);
    check("R10 ser isolated", ser_in_o, 8'hC0);
    per_req_i[0] = 1'b1;
    #1 check("R9 periph owns", soft_in_o, 8'hC4);
    per_req_i = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_push_pull();
    t_open_drain();
    t_periph();
    t_debug();
    t_trace();
    t_loop();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule